// File: doc/BRIEF.md
# Coarse-to-Fine Frequency Acquisition Controller

This block steers the tuning code of a clock-recovery oscillator until its frequency agrees with the rate of the incoming data. A loss-of-lock request from the lock detector starts a new search. Every search begins at the lowest code and climbs upward in large strides. When the oscillator passes the target, the controller steps back once and halves the stride. This continues until a 1 LSB stride is reached.

A measurement window of `WIN_CYC` clock cycles separates tuning updates, so the frequency comparator can settle between them. At the end of each window the controller reads three indications: oscillator slower, oscillator faster, and inside the lock window. If the error is inside the lock window, the controller freezes the code and raises `fine_en`. This hands control to the fine phase loop, and the frequency loop then stays switched off until the next loss-of-lock request.

States: IDLE (after reset, waiting), RESET_CODE (code forced to the bottom), COARSE (climbing with the largest stride), FINE (stride has been reduced at least once), LOCKED (frozen, fine loop enabled). The transitions are as follows:
- START: any state goes to RESET_CODE on `lol_req`.
- BEGIN: RESET_CODE goes to COARSE.
- OVERSHOOT: COARSE or FINE goes to FINE when the oscillator is fast.
- NEAR_TOP: COARSE or FINE goes to FINE when a stride would pass the top code.
- WRAP: COARSE or FINE goes to COARSE when the code is already at the top and the oscillator is still slow.
- LOCK: COARSE or FINE goes to LOCKED when the oscillator is inside the window.

Top module: `facq_ctrl`

## Requirements
- R1: After reset `tune_code` is 0 and `fine_en` is 0. In IDLE both stay unchanged, whatever the comparison inputs do, until `lol_req` is seen.
- R2: A `lol_req` sampled high in any state sets `tune_code` to 0, clears `fine_en` and loads the largest stride, 2^(CODE_W-2), on the same clock edge.
- R3: The first tuning update comes WIN_CYC+1 clock edges after the edge that sampled `lol_req`. Each later update follows the previous one by exactly WIN_CYC edges.
- R4: At a window end with `osc_slow` high, if code + stride does not exceed 2^CODE_W-1, the code rises by the stride. This is the only way the code moves upward.
- R5: At a window end with `osc_fast` high, the code drops by one stride (floored at 0) and the stride halves. The stride never goes below 1.
- R6: At a window end with `osc_slow` high, if code + stride would exceed the top code and the code is not yet at the top, the code is held and the stride halves.
- R7: At a window end with `osc_slow` high and the code at 2^CODE_W-1, the code wraps to 0 and the search resumes with the largest stride.
- R8: At a window end, `in_window` has priority over `osc_fast`, and `osc_fast` has priority over `osc_slow`. With `in_window` high, `fine_en` rises on that edge and the code stays frozen until the next `lol_req`.
- R9: A `lol_req` in the middle of a search abandons it and restarts from code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lol_req | input | 1 | Loss-of-lock request; starts a new acquisition |
| osc_slow | input | 1 | Oscillator frequency is below the target |
| osc_fast | input | 1 | Oscillator frequency is above the target |
| in_window | input | 1 | Frequency error is within the lock window |
| tune_code | output | CODE_W | Oscillator tuning code |
| fine_en | output | 1 | Hands control to the fine phase loop |

## Verification
The assertions check on every cycle that a restart clears the code and reloads the largest stride, and that each update inside a search is one of the legal moves: hold, up by a stride, down by a stride, or wrap to zero. They also check that the stride stays a single power of two that never grows without a restart, and that a locked code stays frozen. Only the bench scenarios can show complete trajectories against a modelled oscillator. These cover overshoot recovery, the halving near the top, the wrap when the target is out of range, the window timing, relock from a locked state and an interrupted search.

// File: rtl/facq_pkg.sv
package facq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET_CODE,
        ST_COARSE,
        ST_FINE,
        ST_LOCKED
    } facq_state_e;

    typedef enum logic [2:0] {
        V_NONE,
        V_LOCK,
        V_BACKOFF,
        V_ADVANCE,
        V_NEARTOP,
        V_WRAP
    } facq_verdict_e;

endpackage

// File: rtl/facq_win_timer.sv
module facq_win_timer #(
    parameter int WIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/facq_step_unit.sv
module facq_step_unit
    import facq_pkg::*;
#(
    parameter int CODE_W         = 10,
    parameter int INIT_STEP_LOG2 = CODE_W - 2
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] step,
    input  logic              osc_slow,
    input  logic              osc_fast,
    input  logic              in_window,
    output facq_verdict_e     verdict,
    output logic [CODE_W-1:0] nxt_code,
    output logic [CODE_W-1:0] nxt_step
);
    localparam logic [CODE_W-1:0] MAX_CODE  = '1;
    localparam logic [CODE_W-1:0] ONE       = {{(CODE_W-1){1'b0}}, 1'b1};
    localparam logic [CODE_W-1:0] INIT_STEP = ONE << INIT_STEP_LOG2;

    logic [CODE_W:0]   sum;
    logic              over_top;
    logic [CODE_W-1:0] half_step;

    assign sum       = {1'b0, code} + {1'b0, step};
    assign over_top  = sum[CODE_W];
    assign half_step = (step > ONE) ? (step >> 1) : ONE;

    always_comb begin
        verdict  = V_NONE;
        nxt_code = code;
        nxt_step = step;
        if (in_window) begin
            verdict = V_LOCK;
        end else if (osc_fast) begin
            verdict  = V_BACKOFF;
            nxt_code = (code >= step) ? (code - step) : '0;
            nxt_step = half_step;
        end else if (osc_slow) begin
            if (!over_top) begin
                verdict  = V_ADVANCE;
                nxt_code = sum[CODE_W-1:0];
            end else if (code == MAX_CODE) begin
                verdict  = V_WRAP;
                nxt_code = '0;
                nxt_step = INIT_STEP;
            end else begin
                verdict  = V_NEARTOP;
                nxt_step = half_step;
            end
        end
    end

endmodule

// File: rtl/facq_ctrl.sv
module facq_ctrl
    import facq_pkg::*;
#(
    parameter int CODE_W         = 10,
    parameter int INIT_STEP_LOG2 = CODE_W - 2,
    parameter int WIN_CYC        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lol_req,
    input  logic              osc_slow,
    input  logic              osc_fast,
    input  logic              in_window,
    output logic [CODE_W-1:0] tune_code,
    output logic              fine_en
);
    localparam logic [CODE_W-1:0] ONE       = {{(CODE_W-1){1'b0}}, 1'b1};
    localparam logic [CODE_W-1:0] INIT_STEP = ONE << INIT_STEP_LOG2;

    facq_state_e       state_q, state_d;
    facq_verdict_e     verdict;
    logic [CODE_W-1:0] code_q, step_q;
    logic [CODE_W-1:0] nxt_code, nxt_step;
    logic              fine_q;
    logic              searching;
    logic              tick;

    assign searching = (state_q == ST_COARSE) || (state_q == ST_FINE);

    facq_win_timer #(
        .WIN_CYC (WIN_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (searching && !lol_req),
        .tick  (tick)
    );

    facq_step_unit #(
        .CODE_W         (CODE_W),
        .INIT_STEP_LOG2 (INIT_STEP_LOG2)
    ) u_step (
        .code      (code_q),
        .step      (step_q),
        .osc_slow  (osc_slow),
        .osc_fast  (osc_fast),
        .in_window (in_window),
        .verdict   (verdict),
        .nxt_code  (nxt_code),
        .nxt_step  (nxt_step)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (lol_req) begin
            state_d = ST_RESET_CODE;                 // START
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_IDLE;
                ST_RESET_CODE: state_d = ST_COARSE;  // BEGIN
                ST_COARSE, ST_FINE: begin
                    if (tick) begin
                        unique case (verdict)
                            V_LOCK:    state_d = ST_LOCKED;  // LOCK
                            V_BACKOFF: state_d = ST_FINE;    // OVERSHOOT
                            V_NEARTOP: state_d = ST_FINE;    // NEAR_TOP
                            V_WRAP:    state_d = ST_COARSE;  // WRAP
                            default:   state_d = state_q;
                        endcase
                    end
                end
                ST_LOCKED:     state_d = ST_LOCKED;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output / datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            step_q <= INIT_STEP;
            fine_q <= 1'b0;
        end else if (lol_req) begin
            code_q <= '0;
            step_q <= INIT_STEP;
            fine_q <= 1'b0;
        end else if (searching && tick) begin
            code_q <= nxt_code;
            step_q <= nxt_step;
            fine_q <= (verdict == V_LOCK);
        end
    end

    assign tune_code = code_q;
    assign fine_en   = fine_q;

endmodule

// File: rtl/facq_chk.sv
module facq_chk
    import facq_pkg::*;
#(
    parameter int CODE_W         = 10,
    parameter int INIT_STEP_LOG2 = CODE_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lol_req,
    input logic              in_window,
    input facq_state_e       state,
    input logic [CODE_W-1:0] step,
    input logic [CODE_W-1:0] tune_code,
    input logic              fine_en
);
    localparam logic [CODE_W-1:0] ONE       = {{(CODE_W-1){1'b0}}, 1'b1};
    localparam logic [CODE_W-1:0] INIT_STEP = ONE << INIT_STEP_LOG2;

    logic [CODE_W-1:0] prev_code, prev_step;
    logic              prev_srch;
    logic              srch_now;

    assign srch_now = (state == ST_COARSE) || (state == ST_FINE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_code <= '0;
            prev_step <= INIT_STEP;
            prev_srch <= 1'b0;
        end else begin
            prev_code <= tune_code;
            prev_step <= step;
            prev_srch <= srch_now && !lol_req;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !lol_req) |=> (tune_code == '0 && !fine_en)); // R1

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        lol_req |=> (tune_code == '0 && !fine_en && step == INIT_STEP)); // R2

    AST_LEGAL_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        prev_srch |-> (tune_code == prev_code
                    || {1'b0, tune_code} == {1'b0, prev_code} + {1'b0, prev_step}
                    || tune_code == prev_code - prev_step
                    || tune_code == '0)); // R4

    AST_STEP_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step) == 1); // R5

    AST_STEP_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        !lol_req |=> (step <= $past(step) || tune_code == '0)); // R5

    AST_LOCK_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fine_en) |-> $past(in_window)); // R8

    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_en && !lol_req) |=> (fine_en && $stable(tune_code))); // R8

    AST_NO_FINE_WHILE_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        srch_now |-> !fine_en); // R9

endmodule

bind facq_ctrl facq_chk #(
    .CODE_W         (CODE_W),
    .INIT_STEP_LOG2 (INIT_STEP_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lol_req   (lol_req),
    .in_window (in_window),
    .state     (state_q),
    .step      (step_q),
    .tune_code (tune_code),
    .fine_en   (fine_en)
);

// File: tb/sim_facq_ctrl.sv
`timescale 1ns/1ps
module sim_facq_ctrl;
    localparam int CODE_W = 10;
    localparam int WIN    = 8;
    localparam int MAXC   = (1 << CODE_W) - 1;
    localparam int INITS  = 1 << (CODE_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lol_req = 1'b0;
    logic              osc_slow, osc_fast, in_window;
    logic [CODE_W-1:0] tune_code;
    logic              fine_en;

    int tgt = 500;
    int tol = 0;

    int n_vec = 0;
    int n_bad = 0;
    int q[$];
    int prev_code = 0;
    int prev_fine = 0;
    int last_seen = 0;
    bit mon_en = 1'b1;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    // oscillator model: frequency proportional to the code
    always_comb begin
        in_window = (int'(tune_code) >= tgt - tol) && (int'(tune_code) <= tgt + tol);
        osc_fast  = int'(tune_code) > tgt + tol;
        osc_slow  = int'(tune_code) < tgt - tol;
    end

    facq_ctrl #(.CODE_W(CODE_W), .WIN_CYC(WIN)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .lol_req   (lol_req),
        .osc_slow  (osc_slow),
        .osc_fast  (osc_fast),
        .in_window (in_window),
        .tune_code (tune_code),
        .fine_en   (fine_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_pair(input int c, input int f);
        if (c != prev_code || f != prev_fine) begin
            q.push_back(c * 2 + f);
            prev_code = c;
            prev_fine = f;
        end
    endtask

    // monitor: every change of (code, fine_en) is compared with the scoreboard
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            automatic int cur = int'(tune_code) * 2 + int'(fine_en);
            if (cur != last_seen) begin
                if (q.size() == 0) begin
                    check(1'b0, {cur_tag, " unexpected change"}, cur, last_seen);
                end else begin
                    automatic int exp = q.pop_front();
                    check(cur == exp, cur_tag, cur, exp);
                end
                last_seen = cur;
            end
        end
    end

    // driver: predicts the trajectory from the requirements, then starts the search
    task automatic run_acq(input int t, input int w, input bit stop_on_wrap, input string tag);
        int c;
        int s;
        bit done;
        c = 0;
        s = INITS;
        done = 1'b0;
        push_pair(0, 0);                                  // R2 restart
        while (!done) begin
            if (c >= t - w && c <= t + w) begin           // R8 lock wins
                push_pair(c, 1);
                done = 1'b1;
            end else if (c > t + w) begin                 // R5 overshoot
                c = (c >= s) ? c - s : 0;
                s = (s > 1) ? s / 2 : 1;
                push_pair(c, 0);
            end else if (c + s <= MAXC) begin             // R4 advance
                c = c + s;
                push_pair(c, 0);
            end else if (c == MAXC) begin                 // R7 wrap
                c = 0;
                s = INITS;
                push_pair(c, 0);
                if (stop_on_wrap) done = 1'b1;
            end else begin                                // R6 near top
                s = (s > 1) ? s / 2 : 1;
            end
        end
        cur_tag = tag;
        @(negedge clk);
        tgt = t;
        tol = w;
        lol_req = 1'b1;
        @(negedge clk);
        lol_req = 1'b0;
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset ignores a slow oscillator
        repeat (3 * WIN) @(negedge clk);
        check(tune_code == 0, "R1 idle code", int'(tune_code), 0);
        check(fine_en == 1'b0, "R1 idle fine_en", int'(fine_en), 0);

        run_acq(300, 2, 1'b0, "R4/R5 overshoot search 300");
        // R8: lock stays frozen although the oscillator now reads fast
        tgt = 100;
        repeat (3 * WIN) @(negedge clk);
        check(tune_code == 300, "R8 frozen code", int'(tune_code), 300);
        check(fine_en == 1'b1, "R8 fine_en held", int'(fine_en), 1);

        run_acq(1020, 0, 1'b0, "R6 near-top halving 1020");
        run_acq(5, 0, 1'b0, "R5 low target 5");
        run_acq(0, 0, 1'b0, "R8 immediate lock at 0");
        run_acq(2000, 0, 1'b1, "R7 wrap out of range");
        run_acq(700, 3, 1'b0, "R2 restart after wrap 700");

        // R3 and R9: window timing, then an interrupted search
        mon_en = 1'b0;
        tgt = 900;
        tol = 0;
        @(negedge clk);
        lol_req = 1'b1;
        @(negedge clk);
        lol_req = 1'b0;
        begin
            int k;
            k = 0;
            do begin @(negedge clk); k++; end while (tune_code == 0 && k < 100);
            check(k == WIN + 1, "R3 first update latency", k, WIN + 1);
            check(tune_code == INITS, "R4 first stride", int'(tune_code), INITS);
            k = 0;
            do begin @(negedge clk); k++; end while (tune_code == INITS && k < 100);
            check(k == WIN, "R3 update spacing", k, WIN);
            check(tune_code == 2 * INITS, "R4 second stride", int'(tune_code), 2 * INITS);
        end
        lol_req = 1'b1;
        @(negedge clk);
        lol_req = 1'b0;
        check(tune_code == 0, "R9 abandon search code", int'(tune_code), 0);
        check(fine_en == 1'b0, "R9 abandon search fine_en", int'(fine_en), 0);
        prev_code = 0;
        prev_fine = 0;
        last_seen = 0;
        mon_en = 1'b1;

        run_acq(123, 1, 1'b0, "R9 resume 123");
        run_acq(640, 0, 1'b0, "R2 relock from locked 640");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (%s) actual=%0d expected=%0d", cur_tag, q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule